// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block decides when the clocks of a small 8-bit microcontroller run. It holds three low-power states beside normal running. In idle, the CPU clock stops while the peripheral clock keeps going. In power-down, both clocks stop and the oscillator is switched off. The fourth state is a settling state that follows an external wake from power-down. The raw oscillator input drives every flop of the block. Each gated clock comes from one toggle flop, so the internal clocks run at half the oscillator rate and the duty cycle of the input does not matter.

Software enters a low-power state by writing the request bits. An enabled interrupt ends idle. Only the two external interrupt pins, when enabled, end power-down. In both cases the block clears the request bit that caused the state. A power-down wake holds the CPU clock off for a programmable number of oscillator cycles so that the oscillator can settle.

The hardware reset pin is synchronised and counted. The internal reset to the core asserts once the pin has been high for a set number of machine cycles. The internal reset does not touch RAM. If reset ends idle, the CPU clock restarts at once and RAM access is inhibited until the internal reset takes over; port access is not inhibited. All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `por_n` is released, `mode` is RUN (0), `osc_en` is 1, `ram_inhibit`, `core_rst`, `idle_bit` and `pd_bit` are 0, and `cpu_clk` and `per_clk` rise once every two oscillator cycles.
- R2: A `ctl_wr` pulse in RUN with `ctl_idle`=1 and `ctl_pd`=0 sets `idle_bit` and `mode` to IDLE (1) one cycle later. `cpu_clk` then stays low while `per_clk` keeps rising every two cycles.
- R3: A `ctl_wr` pulse in RUN with both `ctl_idle` and `ctl_pd` set enters PDOWN (2) one cycle later with `pd_bit`=1 and `idle_bit`=0. Both clocks stop low and `osc_en` goes to 0.
- R4: In IDLE, any high bit of `irq_pending` returns `mode` to RUN one cycle later, clears `idle_bit`, and restarts `cpu_clk`.
- R5: In PDOWN, `irq_pending` has no effect: `mode`, `osc_en` and both clocks stay unchanged.
- R6: In PDOWN, a low level on `ext_int_n[i]` with `ext_en[i]`=1 raises `osc_en` without waiting for a clock. After SYNC_STAGES+1 cycles `mode` becomes STAB (3) and `pd_bit` clears. A pin whose enable bit is 0 is ignored.
- R7: On entry to STAB the block loads `stab_cnt`. `mode` stays STAB for `stab_cnt`+1 cycles with `cpu_clk` low, then returns to RUN. `cpu_clk` rises one cycle after that.
- R8: `core_rst` rises SYNC_STAGES+RST_MC*MC_OSC cycles after `hw_rst` rises, and falls SYNC_STAGES+1 cycles after `hw_rst` falls. While `core_rst` is high, `mode` is RUN and both request bits are clear. A reset that starts in RUN never raises `ram_inhibit`.
- R9: A reset seen in IDLE returns `mode` to RUN SYNC_STAGES+1 cycles after `hw_rst` rises, restarts `cpu_clk` one cycle later, and raises `ram_inhibit`. `ram_inhibit` falls one cycle after `core_rst` rises, and it is never high outside RUN.
- R10: In PDOWN, `osc_en` rises as soon as `hw_rst` is high. Both clocks stay stopped until `core_rst` rises, and the cycle after that `mode` is RUN with `pd_bit` clear. `osc_en` is low only in PDOWN.
- R11: `cpu_clk` and `per_clk` are glitch-free. A high phase lasts exactly one oscillator cycle, and each clock rises only while its domain is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Raw oscillator clock |
| por_n | input | 1 | Power-on reset of the block, active low |
| hw_rst | input | 1 | Hardware reset pin, active high, asynchronous |
| ctl_wr | input | 1 | One-cycle write strobe for the request bits |
| ctl_idle | input | 1 | Idle request value written by `ctl_wr` |
| ctl_pd | input | 1 | Power-down request value written by `ctl_wr` |
| irq_pending | input | NUM_IRQ | Interrupt requests, already masked by their enables |
| ext_int_n | input | 2 | External interrupt pins, active low |
| ext_en | input | 2 | Enable bit for each external interrupt pin |
| stab_cnt | input | STAB_W | Settling count in oscillator cycles after a power-down wake |
| cpu_clk | output | 1 | Gated CPU clock |
| per_clk | output | 1 | Gated peripheral clock (RAM, timers, serial, interrupts) |
| osc_en | output | 1 | Oscillator enable |
| ram_inhibit | output | 1 | Blocks internal RAM access during the reset-from-idle window |
| core_rst | output | 1 | Internal reset to the core and its special registers |
| mode | output | 2 | 0 RUN, 1 IDLE, 2 PDOWN, 3 STAB |
| idle_bit | output | 1 | Idle request bit, cleared by hardware on wake |
| pd_bit | output | 1 | Power-down request bit, cleared by hardware on wake |

## Verification
The bench builds the block with a four-cycle machine cycle, a two-machine-cycle reset qualification, two synchroniser stages, five interrupt lines and a six-bit settling count. With these values the reset counter saturates in eight cycles and a settling window of 0 or 5 cycles fits in a few edges. This lets the bench reach and check every cycle of the reset-from-idle inhibit window and both settling lengths. A scoreboard places each expected value at the exact cycle that the synchroniser, counter and gate registers imply.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_PDOWN = 2'd2,
    PM_STAB  = 2'd3
  } pm_mode_e;
endpackage

// File: rtl/pmc_sync.sv
// Multi-stage synchroniser for asynchronous pins.
module pmc_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pmc_clk_gate.sv
// Toggle flop that divides by two and gates in one register. It stops only
// from the low phase, so a high phase always lasts one full oscillator cycle.
module pmc_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic gclk
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gclk <= 1'b0;
    else if (gclk) gclk <= 1'b0;
    else           gclk <= en;
  end
endmodule

// File: rtl/pmc_rst_ctl.sv
// Qualifies the synchronised reset pin for RST_CYC cycles before asserting
// the internal reset.
module pmc_rst_ctl #(
  parameter int RST_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_seen,
  output logic core_rst
);
  localparam int CW = (RST_CYC < 2) ? 1 : $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      core_rst <= 1'b0;
    end else begin
      if (!rst_seen)        cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + CW'(1);
      core_rst <= rst_seen && (cnt == LAST);
    end
  end
endmodule

// File: rtl/pmc_fsm.sv
// Mode sequencer: request bits, wake decisions, settling count, RAM inhibit.
module pmc_fsm
  import pmc_pkg::*;
#(
  parameter int NUM_IRQ = 5,
  parameter int STAB_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic               ctl_idle,
  input  logic               ctl_pd,
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic               ext_wake,
  input  logic               rst_seen,
  input  logic               core_rst,
  input  logic [STAB_W-1:0]  stab_cnt,
  output pm_mode_e           mode,
  output logic               idle_bit,
  output logic               pd_bit,
  output logic               ram_inhibit
);
  logic [STAB_W-1:0] scnt;
  logic              any_irq;
  logic              wr_ok;

  assign any_irq = |irq_pending;
  assign wr_ok   = ctl_wr && !rst_seen && !ram_inhibit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= PM_RUN;
      idle_bit    <= 1'b0;
      pd_bit      <= 1'b0;
      ram_inhibit <= 1'b0;
      scnt        <= '0;
    end else if (core_rst) begin
      mode        <= PM_RUN;
      idle_bit    <= 1'b0;
      pd_bit      <= 1'b0;
      ram_inhibit <= 1'b0;
    end else begin
      unique case (mode)
        PM_RUN: begin
          if (ram_inhibit && !rst_seen) begin
            ram_inhibit <= 1'b0;
          end else if (wr_ok && ctl_pd) begin
            pd_bit   <= 1'b1;
            idle_bit <= 1'b0;
            mode     <= PM_PDOWN;
          end else if (wr_ok && ctl_idle) begin
            idle_bit <= 1'b1;
            mode     <= PM_IDLE;
          end
        end
        PM_IDLE: begin
          if (rst_seen) begin
            mode        <= PM_RUN;
            ram_inhibit <= 1'b1;
          end else if (any_irq) begin
            mode     <= PM_RUN;
            idle_bit <= 1'b0;
          end
        end
        PM_PDOWN: begin
          if (!rst_seen && ext_wake) begin
            mode   <= PM_STAB;
            pd_bit <= 1'b0;
            scnt   <= stab_cnt;
          end
        end
        PM_STAB: begin
          if (!rst_seen) begin
            if (scnt == '0) mode <= PM_RUN;
            else            scnt <= scnt - STAB_W'(1);
          end
        end
        default: mode <= PM_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_IRQ     = 5,
  parameter int STAB_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int MC_OSC      = 12,
  parameter int RST_MC      = 2
) (
  input  logic               osc_clk,
  input  logic               por_n,
  input  logic               hw_rst,
  input  logic               ctl_wr,
  input  logic               ctl_idle,
  input  logic               ctl_pd,
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic [1:0]         ext_int_n,
  input  logic [1:0]         ext_en,
  input  logic [STAB_W-1:0]  stab_cnt,
  output logic               cpu_clk,
  output logic               per_clk,
  output logic               osc_en,
  output logic               ram_inhibit,
  output logic               core_rst,
  output logic [1:0]         mode,
  output logic               idle_bit,
  output logic               pd_bit
);
  localparam int RST_CYC = RST_MC * MC_OSC;
  localparam int N_DOM   = 2;

  pm_mode_e   mode_q;
  logic       rst_seen;
  logic [1:0] ext_s;
  logic       ext_wake;
  logic       ext_wake_raw;
  logic [N_DOM-1:0] dom_en;
  logic [N_DOM-1:0] dom_clk;

  pmc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(osc_clk), .rst_n(por_n), .d(hw_rst), .q(rst_seen)
  );

  pmc_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_ext_sync (
    .clk(osc_clk), .rst_n(por_n), .d(ext_int_n), .q(ext_s)
  );

  assign ext_wake     = |(~ext_s & ext_en);
  assign ext_wake_raw = |(~ext_int_n & ext_en);

  pmc_rst_ctl #(.RST_CYC(RST_CYC)) u_rst (
    .clk(osc_clk), .rst_n(por_n), .rst_seen(rst_seen), .core_rst(core_rst)
  );

  pmc_fsm #(.NUM_IRQ(NUM_IRQ), .STAB_W(STAB_W)) u_fsm (
    .clk(osc_clk), .rst_n(por_n),
    .ctl_wr(ctl_wr), .ctl_idle(ctl_idle), .ctl_pd(ctl_pd),
    .irq_pending(irq_pending), .ext_wake(ext_wake),
    .rst_seen(rst_seen), .core_rst(core_rst), .stab_cnt(stab_cnt),
    .mode(mode_q), .idle_bit(idle_bit), .pd_bit(pd_bit),
    .ram_inhibit(ram_inhibit)
  );

  // Domain 0 is the CPU, domain 1 the peripherals.
  assign dom_en[0] = (mode_q == PM_RUN);
  assign dom_en[1] = (mode_q == PM_RUN) || (mode_q == PM_IDLE);

  for (genvar g = 0; g < N_DOM; g++) begin : g_dom
    pmc_clk_gate u_gate (
      .clk(osc_clk), .rst_n(por_n), .en(dom_en[g]), .gclk(dom_clk[g])
    );
  end

  assign cpu_clk = dom_clk[0];
  assign per_clk = dom_clk[1];
  assign mode    = mode_q;
  // The pin wake and the reset pin reach the oscillator without a clock edge.
  assign osc_en  = (mode_q != PM_PDOWN) || hw_rst || ext_wake_raw;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int NUM_IRQ = 5
) (
  input logic               osc_clk,
  input logic               por_n,
  input logic [1:0]         mode,
  input logic               cpu_clk,
  input logic               per_clk,
  input logic               osc_en,
  input logic               ram_inhibit,
  input logic               core_rst,
  input logic               idle_bit,
  input logic               pd_bit,
  input logic               ctl_wr,
  input logic               ctl_pd,
  input logic [NUM_IRQ-1:0] irq_pending,
  input logic               rst_seen,
  input logic               ext_wake
);
  localparam logic [1:0] M_RUN = 2'd0, M_IDLE = 2'd1, M_PD = 2'd2, M_STAB = 2'd3;

  assert_cpu_gated_R2: assert property (@(posedge osc_clk) disable iff (!por_n)
    $rose(cpu_clk) |-> $past(mode == M_RUN));

  assert_pd_wins_R3: assert property (@(posedge osc_clk) disable iff (!por_n)
    (ctl_wr && ctl_pd && mode == M_RUN && !core_rst && !rst_seen && !ram_inhibit)
      |=> (mode == M_PD && pd_bit && !idle_bit));

  assert_idle_wake_R4: assert property (@(posedge osc_clk) disable iff (!por_n)
    (mode == M_IDLE && (|irq_pending) && !rst_seen && !core_rst)
      |=> (mode == M_RUN && !idle_bit));

  assert_pd_ignores_irq_R5: assert property (@(posedge osc_clk) disable iff (!por_n)
    (mode == M_PD && !ext_wake && !rst_seen && !core_rst) |=> (mode == M_PD));

  assert_per_gated_R5: assert property (@(posedge osc_clk) disable iff (!por_n)
    $rose(per_clk) |-> $past(mode == M_RUN || mode == M_IDLE));

  assert_stab_clk_off_R7: assert property (@(posedge osc_clk) disable iff (!por_n)
    (mode == M_STAB) |-> !cpu_clk);

  assert_core_rst_clears_R8: assert property (@(posedge osc_clk) disable iff (!por_n)
    core_rst |=> (mode == M_RUN && !idle_bit && !pd_bit));

  assert_inhibit_run_R9: assert property (@(posedge osc_clk) disable iff (!por_n)
    ram_inhibit |-> (mode == M_RUN));

  assert_osc_off_pd_R10: assert property (@(posedge osc_clk) disable iff (!por_n)
    !osc_en |-> (mode == M_PD));

  assert_cpu_high_one_R11: assert property (@(posedge osc_clk) disable iff (!por_n)
    cpu_clk |=> !cpu_clk);

  assert_per_high_one_R11: assert property (@(posedge osc_clk) disable iff (!por_n)
    per_clk |=> !per_clk);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .osc_clk(osc_clk), .por_n(por_n), .mode(mode), .cpu_clk(cpu_clk),
  .per_clk(per_clk), .osc_en(osc_en), .ram_inhibit(ram_inhibit),
  .core_rst(core_rst), .idle_bit(idle_bit), .pd_bit(pd_bit),
  .ctl_wr(ctl_wr), .ctl_pd(ctl_pd), .irq_pending(irq_pending),
  .rst_seen(rst_seen), .ext_wake(ext_wake)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int PERIOD  = 10;
  localparam int P_NIRQ  = 5;
  localparam int P_STABW = 6;
  localparam int P_SYNC  = 2;
  localparam int P_MC    = 4;
  localparam int P_RSTMC = 2;
  localparam int P_RST   = P_MC * P_RSTMC;

  typedef enum int {S_MODE, S_CPU, S_PER, S_OSC, S_INH, S_CRST, S_IDB, S_PDB} sig_e;
  typedef struct {
    int    cyc;
    sig_e  sig;
    int    exp;
    string req;
  } exp_t;

  logic osc_clk = 1'b0;
  logic por_n = 1'b0;
  logic hw_rst = 1'b0;
  logic ctl_wr = 1'b0, ctl_idle = 1'b0, ctl_pd = 1'b0;
  logic [P_NIRQ-1:0] irq_pending = '0;
  logic [1:0] ext_int_n = 2'b11;
  logic [1:0] ext_en = 2'b00;
  logic [P_STABW-1:0] stab_cnt = '0;
  logic cpu_clk, per_clk, osc_en, ram_inhibit, core_rst, idle_bit, pd_bit;
  logic [1:0] mode;

  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  pwr_mode_ctrl #(
    .NUM_IRQ(P_NIRQ), .STAB_W(P_STABW), .SYNC_STAGES(P_SYNC),
    .MC_OSC(P_MC), .RST_MC(P_RSTMC)
  ) uut (
    .osc_clk(osc_clk), .por_n(por_n), .hw_rst(hw_rst), .ctl_wr(ctl_wr),
    .ctl_idle(ctl_idle), .ctl_pd(ctl_pd), .irq_pending(irq_pending),
    .ext_int_n(ext_int_n), .ext_en(ext_en), .stab_cnt(stab_cnt),
    .cpu_clk(cpu_clk), .per_clk(per_clk), .osc_en(osc_en),
    .ram_inhibit(ram_inhibit), .core_rst(core_rst), .mode(mode),
    .idle_bit(idle_bit), .pd_bit(pd_bit)
  );

  always #(PERIOD/2) osc_clk = ~osc_clk;

  function automatic int sig_val(sig_e s);
    case (s)
      S_MODE:  return int'(mode);
      S_CPU:   return int'(cpu_clk);
      S_PER:   return int'(per_clk);
      S_OSC:   return int'(osc_en);
      S_INH:   return int'(ram_inhibit);
      S_CRST:  return int'(core_rst);
      S_IDB:   return int'(idle_bit);
      default: return int'(pd_bit);
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // Driver side: place an expectation DLY samples after the current one.
  task automatic expect_at(int dly, sig_e s, int v, string req);
    exp_t e;
    e.cyc = cyc + dly; e.sig = s; e.exp = v; e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: samples a quarter period after each rising edge.
  int cpu_hi_prev = 0;
  int dbl_high = 0;
  always @(posedge osc_clk) begin
    #(PERIOD/4);
    cyc++;
    if (mon_on) begin
      if (cpu_clk && cpu_hi_prev != 0) dbl_high++;
      cpu_hi_prev = int'(cpu_clk);
      for (int i = exp_q.size() - 1; i >= 0; i--) begin
        if (exp_q[i].cyc == cyc) begin
          check(sig_val(exp_q[i].sig) == exp_q[i].exp, exp_q[i].req,
                exp_q[i].sig.name(), sig_val(exp_q[i].sig), exp_q[i].exp);
          exp_q.delete(i);
        end
      end
    end
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge osc_clk);
  endtask

  task automatic count_rises(int n, output int rc, output int rp);
    logic pc, pp;
    rc = 0; rp = 0;
    pc = cpu_clk; pp = per_clk;
    for (int i = 0; i < n; i++) begin
      @(negedge osc_clk);
      if (cpu_clk && !pc) rc++;
      if (per_clk && !pp) rp++;
      pc = cpu_clk; pp = per_clk;
    end
  endtask

  task automatic write_ctl(bit idl, bit pd);
    ctl_wr = 1'b1; ctl_idle = idl; ctl_pd = pd;
    @(negedge osc_clk);
    ctl_wr = 1'b0; ctl_idle = 1'b0; ctl_pd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int rc, rp;
    wait_cyc(3);
    por_n = 1'b1;
    mon_on = 1'b1;
    wait_cyc(2);

    // R1: reset state and free-running clocks
    check(mode == 2'd0, "R1", "mode", mode, 0);
    check(osc_en == 1'b1, "R1", "osc_en", osc_en, 1);
    check({ram_inhibit, core_rst, idle_bit, pd_bit} == 4'b0, "R1", "flags",
          {ram_inhibit, core_rst, idle_bit, pd_bit}, 0);
    count_rises(8, rc, rp);
    check(rc == 4, "R1", "cpu rises", rc, 4);
    check(rp == 4, "R1", "per rises", rp, 4);

    // R2: idle entry
    expect_at(1, S_MODE, 1, "R2");
    expect_at(1, S_IDB, 1, "R2");
    write_ctl(1'b1, 1'b0);
    wait_cyc(2);
    count_rises(8, rc, rp);
    check(rc == 0, "R2", "cpu rises in idle", rc, 0);
    check(rp == 4, "R2", "per rises in idle", rp, 4);

    // R4: interrupt wakes idle
    irq_pending = 5'b01000;
    expect_at(1, S_MODE, 0, "R4");
    expect_at(1, S_IDB, 0, "R4");
    wait_cyc(1);
    irq_pending = '0;
    count_rises(8, rc, rp);
    check(rc == 4, "R4", "cpu rises after wake", rc, 4);

    // R3: both bits written, power-down wins
    expect_at(1, S_MODE, 2, "R3");
    expect_at(1, S_PDB, 1, "R3");
    expect_at(1, S_IDB, 0, "R3");
    expect_at(3, S_OSC, 0, "R3");
    write_ctl(1'b1, 1'b1);
    wait_cyc(2);
    count_rises(6, rc, rp);
    check(rc == 0 && rp == 0, "R3", "rises in power-down", rc + rp, 0);

    // R5: interrupts ignored in power-down
    irq_pending = '1;
    expect_at(6, S_MODE, 2, "R5");
    expect_at(6, S_OSC, 0, "R5");
    expect_at(6, S_PER, 0, "R5");
    wait_cyc(7);
    irq_pending = '0;

    // R6: disabled pin ignored
    ext_en = 2'b01;
    ext_int_n = 2'b01;
    #1;
    check(osc_en == 1'b0, "R6", "osc_en disabled pin", osc_en, 0);
    expect_at(5, S_MODE, 2, "R6");
    expect_at(5, S_PDB, 1, "R6");
    wait_cyc(6);
    ext_int_n = 2'b11;
    wait_cyc(1);

    // R6/R7: enabled pin wakes, settle for 5 cycles
    stab_cnt = 6'd5;
    ext_int_n = 2'b10;
    #1;
    check(osc_en == 1'b1, "R6", "osc_en enabled pin", osc_en, 1);
    expect_at(P_SYNC, S_MODE, 2, "R6");
    expect_at(P_SYNC + 1, S_MODE, 3, "R6");
    expect_at(P_SYNC + 1, S_PDB, 0, "R6");
    for (int j = P_SYNC + 1; j <= P_SYNC + 5 + 2; j++) expect_at(j, S_CPU, 0, "R7");
    expect_at(P_SYNC + 5 + 1, S_MODE, 3, "R7");
    expect_at(P_SYNC + 5 + 2, S_MODE, 0, "R7");
    expect_at(P_SYNC + 5 + 3, S_CPU, 1, "R7");
    @(negedge osc_clk);
    ext_int_n = 2'b11;
    wait_cyc(P_SYNC + 5 + 4);

    // R7: zero settling count
    stab_cnt = 6'd0;
    write_ctl(1'b0, 1'b1);
    wait_cyc(2);
    ext_int_n = 2'b10;
    expect_at(P_SYNC + 1, S_MODE, 3, "R7");
    expect_at(P_SYNC + 2, S_MODE, 0, "R7");
    @(negedge osc_clk);
    ext_int_n = 2'b11;
    wait_cyc(P_SYNC + 4);

    // R8: reset from run
    hw_rst = 1'b1;
    expect_at(P_SYNC + P_RST - 1, S_CRST, 0, "R8");
    expect_at(P_SYNC + P_RST, S_CRST, 1, "R8");
    expect_at(5, S_INH, 0, "R8");
    expect_at(P_SYNC + P_RST, S_INH, 0, "R8");
    expect_at(P_SYNC + P_RST + 1, S_MODE, 0, "R8");
    wait_cyc(P_SYNC + P_RST + 2);
    hw_rst = 1'b0;
    expect_at(P_SYNC, S_CRST, 1, "R8");
    expect_at(P_SYNC + 1, S_CRST, 0, "R8");
    wait_cyc(P_SYNC + 3);

    // R9: reset ends idle, RAM inhibit window
    write_ctl(1'b1, 1'b0);
    wait_cyc(3);
    hw_rst = 1'b1;
    expect_at(P_SYNC, S_MODE, 1, "R9");
    expect_at(P_SYNC + 1, S_MODE, 0, "R9");
    expect_at(P_SYNC + 1, S_INH, 1, "R9");
    expect_at(P_SYNC + 1, S_IDB, 1, "R9");
    expect_at(P_SYNC + 2, S_CPU, 1, "R9");
    expect_at(P_SYNC + 3, S_CPU, 0, "R9");
    expect_at(P_SYNC + P_RST, S_CRST, 1, "R9");
    expect_at(P_SYNC + P_RST, S_INH, 1, "R9");
    expect_at(P_SYNC + P_RST + 1, S_INH, 0, "R9");
    expect_at(P_SYNC + P_RST + 1, S_IDB, 0, "R9");
    wait_cyc(P_SYNC + P_RST + 2);
    hw_rst = 1'b0;
    wait_cyc(P_SYNC + 3);

    // R10: reset ends power-down
    write_ctl(1'b0, 1'b1);
    wait_cyc(3);
    check(osc_en == 1'b0, "R10", "osc_en before reset", osc_en, 0);
    hw_rst = 1'b1;
    #1;
    check(osc_en == 1'b1, "R10", "osc_en on reset pin", osc_en, 1);
    expect_at(P_SYNC + P_RST, S_MODE, 2, "R10");
    expect_at(P_SYNC + P_RST, S_CPU, 0, "R10");
    expect_at(P_SYNC + P_RST + 1, S_MODE, 0, "R10");
    expect_at(P_SYNC + P_RST + 1, S_PDB, 0, "R10");
    expect_at(P_SYNC + P_RST + 1, S_CPU, 0, "R10");
    expect_at(P_SYNC + P_RST + 1, S_INH, 0, "R10");
    wait_cyc(P_SYNC + P_RST + 3);
    hw_rst = 1'b0;
    wait_cyc(P_SYNC + 3);

    // R11: no stretched high phase seen by the monitor
    check(dbl_high == 0, "R11", "cpu double-high samples", dbl_high, 0);
    check(exp_q.size() == 0, "R1", "unchecked expectations", exp_q.size(), 0);
    finish_run();
  end
endmodule